// File: doc/BRIEF.md
# Balanced Ternary Ripple Adder

This block adds two balanced-ternary words and a carry-in trit, producing a result word and a carry-out trit. Every trit holds -1, 0 or +1 and travels on a two-bit code. The block is purely combinational: outputs follow inputs with no clock and no state.

Each digit position is a full adder. It is built from two primitive gates. The mod-3 sum gate wraps a two-trit total back into {-1, 0, +1}. The consensus gate returns the shared value of its inputs when they agree and 0 when they differ. Positions are chained from the least significant trit upward, so the carry ripples through all N positions. The word width N is a parameter with a default of 4 trits.

A word packs trit k into bits [2k+1:2k]. Trit 0 is the least significant and carries weight 3^0.

Top module: `tern_ripple_adder`

## Requirements
- R1: Trit codes are 2'b00 = 0, 2'b01 = +1 and 2'b11 = -1. Every result trit and the carry-out use only these three codes.
- R2: With the second operand and the carry-in all zero, the result equals the first operand and the carry-out is 0.
- R3: When every trit of the second operand is the negation of the matching trit of the first, and the carry-in is 0, the result is all zero and the carry-out is 0.
- R4: For all legal inputs, value(result) + carry_out × 3^N equals value(a) + value(b) + carry_in. Here value(x) = Σ trit_k × 3^k.
- R5: Two -1 trits in position 0, with all other inputs zero, give +1 in result trit 0 and -1 in result trit 1. This is the carry of the consensus of two -1 inputs.
- R6: Two +1 trits in position 0, with all other inputs zero, give -1 in result trit 0 and +1 in result trit 1.
- R7: A carry from the top position appears on the carry-out. All +1 operands with a carry-in of +1 give an all-zero result and a carry-out of +1. All -1 operands with a carry-in of -1 give an all-zero result and a carry-out of -1.
- R8: An input trit coded 2'b10 is read as 0.
- R9: The carry-in enters at position 0 only. With both operands zero, the result is the carry-in in trit 0 and zero in every other trit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 2*N | First operand, trit k in bits [2k+1:2k] |
| opb_i | input | 2*N | Second operand, same packing |
| carry_i | input | 2 | Carry-in trit |
| sum_o | output | 2*N | Result word, same packing |
| carry_o | output | 2 | Carry-out trit from the top position |

## Verification
The arithmetic and identity assertions take for granted that every input trit uses a legal code. They are gated so that they stay silent whenever any operand trit or the carry-in is coded 2'b10. The output-code assertion holds for every input.

The main stimulus builds operands only from the three legal codes. It sweeps every pair of 4-trit operands and every carry-in. Illegal codes are applied only in the directed R8 cases, where the arithmetic assertions stand aside.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_Z = 2'b00;
  localparam trit_t TRIT_P = 2'b01;
  localparam trit_t TRIT_N = 2'b11;

  // 2'b10 is not a legal code; it reads as zero
  function automatic trit_t trit_norm(input trit_t t);
    return (t == 2'b10) ? TRIT_Z : t;
  endfunction
endpackage

// File: rtl/tern_sum_gate.sv
module tern_sum_gate
  import tern_pkg::*;
(
  input  trit_t x_i,
  input  trit_t y_i,
  output trit_t s_o
);
  trit_t x_n, y_n;

  assign x_n = trit_norm(x_i);
  assign y_n = trit_norm(y_i);

  always_comb begin
    unique case ({x_n, y_n})
      {TRIT_N, TRIT_N}: s_o = TRIT_P;
      {TRIT_N, TRIT_Z}: s_o = TRIT_N;
      {TRIT_N, TRIT_P}: s_o = TRIT_Z;
      {TRIT_Z, TRIT_N}: s_o = TRIT_N;
      {TRIT_Z, TRIT_Z}: s_o = TRIT_Z;
      {TRIT_Z, TRIT_P}: s_o = TRIT_P;
      {TRIT_P, TRIT_N}: s_o = TRIT_Z;
      {TRIT_P, TRIT_Z}: s_o = TRIT_P;
      {TRIT_P, TRIT_P}: s_o = TRIT_N;
      default:          s_o = TRIT_Z;
    endcase
  end
endmodule

// File: rtl/tern_cons_gate.sv
module tern_cons_gate
  import tern_pkg::*;
(
  input  trit_t x_i,
  input  trit_t y_i,
  output trit_t c_o
);
  trit_t x_n, y_n;

  assign x_n = trit_norm(x_i);
  assign y_n = trit_norm(y_i);
  assign c_o = (x_n == y_n) ? x_n : TRIT_Z;
endmodule

// File: rtl/tern_full_adder.sv
module tern_full_adder
  import tern_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t c_i,
  output trit_t s_o,
  output trit_t c_o
);
  trit_t s_ab, c_ab, c_sc;

  tern_sum_gate  u_sum_ab (.x_i(a_i),  .y_i(b_i), .s_o(s_ab));
  tern_cons_gate u_cns_ab (.x_i(a_i),  .y_i(b_i), .c_o(c_ab));
  tern_sum_gate  u_sum_sc (.x_i(s_ab), .y_i(c_i), .s_o(s_o));
  tern_cons_gate u_cns_sc (.x_i(s_ab), .y_i(c_i), .c_o(c_sc));
  // at most one partial carry is nonzero unless they cancel, so a sum merges them
  tern_sum_gate  u_sum_cc (.x_i(c_ab), .y_i(c_sc), .s_o(c_o));
endmodule

// File: rtl/tern_ripple_adder.sv
module tern_ripple_adder
  import tern_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [2*N-1:0] opa_i,
  input  logic [2*N-1:0] opb_i,
  input  logic [1:0]     carry_i,
  output logic [2*N-1:0] sum_o,
  output logic [1:0]     carry_o
);
  localparam int W = 2 * N;

  trit_t chain [N+1];

  assign chain[0] = carry_i;

  for (genvar k = 0; k < N; k++) begin : g_pos
    trit_t s_k;
    tern_full_adder u_fa (
      .a_i(opa_i[2*k +: 2]),
      .b_i(opb_i[2*k +: 2]),
      .c_i(chain[k]),
      .s_o(s_k),
      .c_o(chain[k+1])
    );
    assign sum_o[2*k +: 2] = s_k;
  end

  assign carry_o = chain[N];

  logic unused_w;
  assign unused_w = (W == 0);
endmodule

// File: rtl/tern_ripple_adder_chk.sv
module tern_ripple_adder_chk #(
  parameter int N = 4
) (
  input logic [2*N-1:0] opa_i,
  input logic [2*N-1:0] opb_i,
  input logic [1:0]     carry_i,
  input logic [2*N-1:0] sum_o,
  input logic [1:0]     carry_o
);
  function automatic int tv(input logic [1:0] t);
    return (t == 2'b01) ? 1 : (t == 2'b11) ? -1 : 0;
  endfunction

  function automatic int wv(input logic [2*N-1:0] w);
    int acc = 0;
    int p = 1;
    for (int k = 0; k < N; k++) begin
      acc += tv(w[2*k +: 2]) * p;
      p *= 3;
    end
    return acc;
  endfunction

  function automatic bit legal(input logic [2*N-1:0] w);
    for (int k = 0; k < N; k++)
      if (w[2*k +: 2] == 2'b10) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit is_neg(input logic [2*N-1:0] x, input logic [2*N-1:0] y);
    for (int k = 0; k < N; k++)
      if (tv(x[2*k +: 2]) != -tv(y[2*k +: 2])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int pow3n();
    int p = 1;
    for (int k = 0; k < N; k++) p *= 3;
    return p;
  endfunction

  logic known, ok_in;

  assign known = !$isunknown({opa_i, opb_i, carry_i, sum_o, carry_o});
  assign ok_in = legal(opa_i) && legal(opb_i) && (carry_i != 2'b10);

  always_comb begin
    if (known) begin
      AST_LEGAL_OUT: assert (legal(sum_o) && carry_o != 2'b10) else $error("illegal output code"); // R1
      if (ok_in) begin
        AST_ARITH: assert (wv(sum_o) + tv(carry_o) * pow3n() == wv(opa_i) + wv(opb_i) + tv(carry_i))
          else $error("sum mismatch"); // R4
        if (opb_i == '0 && carry_i == 2'b00)
          AST_ZERO_IDENT: assert (sum_o == opa_i && carry_o == 2'b00) else $error("identity broken"); // R2
        if (carry_i == 2'b00 && is_neg(opa_i, opb_i))
          AST_CANCEL: assert (sum_o == '0 && carry_o == 2'b00) else $error("cancel broken"); // R3
        if (opa_i == '0 && opb_i == '0)
          AST_CIN_POS0: assert (sum_o == {{(2*N-2){1'b0}}, carry_i} && carry_o == 2'b00)
            else $error("carry-in placement"); // R9
      end
    end
  end
endmodule

bind tern_ripple_adder tern_ripple_adder_chk #(.N(N)) u_chk (
  .opa_i(opa_i), .opb_i(opb_i), .carry_i(carry_i), .sum_o(sum_o), .carry_o(carry_o)
);

// File: tb/tern_ripple_adder_bench.sv
module tern_ripple_adder_bench;
  localparam int N = 4;
  localparam int P3 = 81;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2*N-1:0] opa, opb, sum;
  logic [1:0] cin, cout;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tern_ripple_adder #(.N(N)) u_tern_ripple_adder (
    .opa_i(opa), .opb_i(opb), .carry_i(cin), .sum_o(sum), .carry_o(cout)
  );

  function automatic logic [1:0] enc(input int v);
    return (v > 0) ? 2'b01 : (v < 0) ? 2'b11 : 2'b00;
  endfunction

  function automatic int dec(input logic [1:0] t);
    return (t == 2'b01) ? 1 : (t == 2'b11) ? -1 : 0;
  endfunction

  function automatic logic [2*N-1:0] to_word(input int v);
    logic [2*N-1:0] w = '0;
    int r = v;
    for (int k = 0; k < N; k++) begin
      int m = ((r % 3) + 3) % 3;
      int d = (m == 2) ? -1 : m;
      w[2*k +: 2] = enc(d);
      r = (r - d) / 3;
    end
    return w;
  endfunction

  function automatic int from_word(input logic [2*N-1:0] w);
    int acc = 0;
    int p = 1;
    for (int k = 0; k < N; k++) begin
      acc += dec(w[2*k +: 2]) * p;
      p *= 3;
    end
    return acc;
  endfunction

  function automatic bit legal_out(input logic [2*N-1:0] w, input logic [1:0] c);
    for (int k = 0; k < N; k++) if (w[2*k +: 2] == 2'b10) return 1'b0;
    return c != 2'b10;
  endfunction

  task automatic apply(input logic [2*N-1:0] a, input logic [2*N-1:0] b, input logic [1:0] c);
    @(posedge clk);
    #1;
    opa = a; opb = b; cin = c;
    @(negedge clk);
  endtask

  task automatic chk_word(input string req, input logic [2*N-1:0] es, input logic [1:0] ec);
    checks++;
    if (sum !== es || cout !== ec) begin
      fails++;
      $display("FAIL %s: sum=%b carry=%b expected sum=%b carry=%b", req, sum, cout, es, ec);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    opa = '0; opb = '0; cin = 2'b00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // reset/idle state: zero inputs give zero outputs (R2, R9)
    apply('0, '0, 2'b00);
    chk_word("R2 idle", '0, 2'b00);

    // R9: carry-in lands in trit 0 only
    apply('0, '0, 2'b01);
    chk_word("R9 cin+", 8'b00_00_00_01, 2'b00);
    apply('0, '0, 2'b11);
    chk_word("R9 cin-", 8'b00_00_00_11, 2'b00);

    // R5 / R6: position carries
    apply(8'b00_00_00_11, 8'b00_00_00_11, 2'b00);
    chk_word("R5", 8'b00_00_11_01, 2'b00);
    apply(8'b00_00_00_01, 8'b00_00_00_01, 2'b00);
    chk_word("R6", 8'b00_00_01_11, 2'b00);

    // R7: carry out of top position
    apply(8'b01_01_01_01, 8'b01_01_01_01, 2'b01);
    chk_word("R7 pos", '0, 2'b01);
    apply(8'b11_11_11_11, 8'b11_11_11_11, 2'b11);
    chk_word("R7 neg", '0, 2'b11);

    // R3: operand plus its negation
    apply(8'b01_11_00_01, 8'b11_01_00_11, 2'b00);
    chk_word("R3", '0, 2'b00);

    // R2: zero identity on a mixed word
    apply(8'b11_01_11_00, '0, 2'b00);
    chk_word("R2 mixed", 8'b11_01_11_00, 2'b00);

    // R8: 2'b10 reads as 0
    apply(8'b01_10_00_01, '0, 2'b00);
    chk_word("R8 a", 8'b01_00_00_01, 2'b00);
    apply(8'b00_00_00_01, 8'b10_10_10_10, 2'b10);
    chk_word("R8 b cin", 8'b00_00_00_01, 2'b00);

    // R4 / R1: exhaustive sweep against an integer model
    for (int a = -HALF; a <= HALF; a++) begin
      for (int b = -HALF; b <= HALF; b++) begin
        for (int c = -1; c <= 1; c++) begin
          int exp_total;
          int got;
          apply(to_word(a), to_word(b), enc(c));
          exp_total = a + b + c;
          got = from_word(sum) + dec(cout) * P3;
          checks++;
          if (got != exp_total || !legal_out(sum, cout)) begin
            fails++;
            $display("FAIL R4/R1: a=%0d b=%0d c=%0d got=%0d expected=%0d", a, b, c, got, exp_total);
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule